// File: doc/BRIEF.md
# Return Address Stack

This block predicts the targets of function returns in the front end of a RISC-V core. Each cycle it may be offered one instruction word together with the address of that instruction. It classifies the word as a call, a return or neither. A call pushes the address of the following instruction, which is the instruction's address plus 4, onto a small stack. A return pops the stack, and in the same cycle the popped value appears on the prediction outputs with a valid flag. Words that are neither calls nor returns leave the stack untouched.

The storage is a circular array of `DEPTH` entries (8 by default) addressed by a top pointer. A level state machine tracks the fill level. It has three states:
- `ST_EMPTY`: no entries are held.
- `ST_PART`: between one and `DEPTH-1` entries are held.
- `ST_FULL`: `DEPTH` entries are held.

The transitions are as follows:
- A push in `ST_EMPTY` moves to `ST_PART`.
- In `ST_PART`, a push that reaches `DEPTH` entries moves to `ST_FULL`.
- In `ST_PART`, a pop that leaves no entries moves to `ST_EMPTY`.
- All other pushes and pops in `ST_PART` stay in `ST_PART`.
- A push in `ST_FULL` stays in `ST_FULL` and overwrites the oldest entry.
- A pop in `ST_FULL` moves to `ST_PART`.
- A return in `ST_EMPTY` stays in `ST_EMPTY`, leaves the pointer where it is, and gives an invalid prediction.

Top module: `ret_addr_stack`

## Requirements
- R1: With `in_valid` high, a word with opcode bits [6:0] = 1101111 and destination bits [11:7] = 1 is a call. It pushes `in_pc + 4`.
- R2: With `in_valid` high, a word with opcode 1100111, bits [14:12] = 000 and destination 1 is a call whatever its source bits [19:15] hold, including source 1. It pushes `in_pc + 4`.
- R3: With `in_valid` high, a word with opcode 1100111, bits [14:12] = 000, destination 0 and source 1 is a return. If the stack is not empty, `pred_valid` is 1 in that same cycle, `pred_target` equals the most recently pushed live entry, and that entry is removed.
- R4: Returns deliver the pushed addresses in last-in, first-out order across mixed sequences of calls and returns.
- R5: A push onto a stack that already holds `DEPTH` entries overwrites the oldest entry. The following `DEPTH` returns give the newest `DEPTH` addresses, and the return after those is invalid.
- R6: A return on an empty stack gives `pred_valid` = 0 and `pred_target` = 0 and does not move the pointer. A later call followed by a return still predicts that call's address.
- R7: Any other word leaves the stack contents and pointer unchanged. This includes a jump-and-link with another destination, a register jump with another source, and a register jump with non-zero bits [14:12].
- R8: After reset, and after a reset in the middle of operation, the stack is empty and a return gives `pred_valid` = 0.
- R9: With `in_valid` low, no word has any effect on the stack, and `pred_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_instr | input | 32 | Instruction word |
| in_pc | input | XLEN | Address of the instruction |
| pred_valid | output | 1 | A return hit a non-empty stack this cycle |
| pred_target | output | XLEN | Predicted return target; 0 when not valid |

## Verification
Two functions can fall in the same cycle: a push onto a full stack and the loss of the oldest entry it evicts. The bench provokes this by issuing `DEPTH+1` calls with distinct addresses and then draining the stack. The check is that the first `DEPTH` returns yield the newest addresses in reverse order while the evicted first address never appears, and that the next return is invalid. A second pairing is a return on an empty stack followed by a call. This is judged by requiring that the next return predicts exactly that call's address.

// File: rtl/ret_addr_stack_pkg.sv
package ret_addr_stack_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } ras_level_e;

    localparam logic [6:0] OPC_JUMP_LINK = 7'b1101111;
    localparam logic [6:0] OPC_JUMP_REG  = 7'b1100111;
    localparam logic [2:0] F3_JUMP_REG   = 3'b000;
    localparam logic [4:0] REG_LINK      = 5'd1;
    localparam logic [4:0] REG_ZERO      = 5'd0;

endpackage

// File: rtl/ras_classify.sv
module ras_classify
    import ret_addr_stack_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        word_ok,
    input  logic [31:0] word,
    output logic        is_call,
    output logic        is_ret
);

    logic [6:0] opc;
    logic [4:0] rd_f;
    logic [4:0] rs1_f;
    logic [2:0] f3;
    logic       jl_hit;
    logic       jr_hit;

    always_comb begin
        opc    = word[6:0];
        rd_f   = word[11:7];
        f3     = word[14:12];
        rs1_f  = word[19:15];
        jl_hit = (opc == OPC_JUMP_LINK);
        jr_hit = (opc == OPC_JUMP_REG) && (f3 == F3_JUMP_REG);
        is_call = word_ok && (jl_hit || jr_hit) && (rd_f == REG_LINK);
        is_ret  = word_ok && jr_hit && (rd_f == REG_ZERO) && (rs1_f == REG_LINK);
    end

    // R2: a single word is never both a call and a return
    assert_call_ret_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({is_call, is_ret}));

endmodule

// File: rtl/ras_level_ctrl.sv
module ras_level_ctrl
    import ret_addr_stack_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          do_push,
    input  logic          do_ret,
    output logic          pop_ok,
    output logic          wr_en,
    output logic [PW-1:0] wr_idx,
    output logic [PW-1:0] rd_idx
);

    localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_CNT  = CW'(1);

    ras_level_e    state_q, state_n;
    logic [PW-1:0] top_q, top_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [PW-1:0] inc_idx, dec_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            top_q   <= '0;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            top_q   <= top_n;
            cnt_q   <= cnt_n;
        end
    end

    always_comb begin
        inc_idx = (top_q == LAST_IDX) ? '0 : top_q + 1'b1;
        dec_idx = (top_q == '0) ? LAST_IDX : top_q - 1'b1;
        state_n = state_q;
        top_n   = top_q;
        cnt_n   = cnt_q;
        pop_ok  = 1'b0;
        wr_en   = do_push;
        wr_idx  = inc_idx;
        rd_idx  = top_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (do_push) begin
                    top_n   = inc_idx;
                    cnt_n   = ONE_CNT;
                    state_n = (DEPTH == 1) ? ST_FULL : ST_PART;
                end
            end
            ST_PART: begin
                if (do_push) begin
                    top_n   = inc_idx;
                    cnt_n   = cnt_q + 1'b1;
                    state_n = (cnt_q == FULL_CNT - 1'b1) ? ST_FULL : ST_PART;
                end else if (do_ret) begin
                    pop_ok  = 1'b1;
                    top_n   = dec_idx;
                    cnt_n   = cnt_q - 1'b1;
                    state_n = (cnt_q == ONE_CNT) ? ST_EMPTY : ST_PART;
                end
            end
            ST_FULL: begin
                if (do_push) begin
                    top_n = inc_idx;
                end else if (do_ret) begin
                    pop_ok  = 1'b1;
                    top_n   = dec_idx;
                    cnt_n   = cnt_q - 1'b1;
                    state_n = (DEPTH == 1) ? ST_EMPTY : ST_PART;
                end
            end
            default: begin
                state_n = ST_EMPTY;
                top_n   = '0;
                cnt_n   = '0;
            end
        endcase
    end

    // R1: a push makes the written slot the new top
    assert_push_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> (top_q == $past(wr_idx)));

    // R3: an accepted return removes exactly one entry
    assert_pop_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pop_ok |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R5: the full state always holds exactly DEPTH entries
    assert_full_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL) |-> (cnt_q == FULL_CNT));

    // R6: a return on an empty stack moves nothing
    assert_empty_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ret && state_q == ST_EMPTY) |=> ($stable(top_q) && state_q == ST_EMPTY));

    // R7: no call and no return leaves pointer and level alone
    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_push && !do_ret) |=> ($stable(top_q) && $stable(cnt_q)));

endmodule

// File: rtl/ras_store.sv
module ras_store #(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [PW-1:0]   wr_idx,
    input  logic [XLEN-1:0] wr_data,
    input  logic [PW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data
);

    logic [XLEN-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            slots[wr_idx] <= wr_data;
        end
    end

    assign rd_data = slots[rd_idx];

endmodule

// File: rtl/ret_addr_stack.sv
module ret_addr_stack #(
    parameter int DEPTH = 8,
    parameter int XLEN  = 32,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [XLEN-1:0] in_pc,
    output logic            pred_valid,
    output logic [XLEN-1:0] pred_target
);

    logic            call_hit;
    logic            ret_hit;
    logic            pop_ok;
    logic            wr_en;
    logic [PW-1:0]   wr_idx;
    logic [PW-1:0]   rd_idx;
    logic [XLEN-1:0] rd_data;
    logic [XLEN-1:0] link_addr;

    assign link_addr = in_pc + XLEN'(4);

    ras_classify u_classify (
        .clk     (clk),
        .rst_n   (rst_n),
        .word_ok (in_valid),
        .word    (in_instr),
        .is_call (call_hit),
        .is_ret  (ret_hit)
    );

    ras_level_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .do_push (call_hit),
        .do_ret  (ret_hit),
        .pop_ok  (pop_ok),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .rd_idx  (rd_idx)
    );

    ras_store #(.DEPTH(DEPTH), .XLEN(XLEN)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (link_addr),
        .rd_idx  (rd_idx),
        .rd_data (rd_data)
    );

    assign pred_valid  = pop_ok;
    assign pred_target = pop_ok ? rd_data : '0;

    // R3: a prediction is only ever raised by a classified return
    assert_pred_from_ret_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |-> ret_hit);

    // R9: nothing is predicted for an idle input slot
    assert_idle_no_pred_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> !pred_valid);

endmodule

// File: tb/test_ret_addr_stack.sv
module test_ret_addr_stack;

    localparam int DEPTH = 8;
    localparam int XLEN  = 32;
    localparam int NVEC  = 14;

    localparam logic [31:0] W_CALL_JL   = 32'h0000_00EF; // jump-and-link, rd=1
    localparam logic [31:0] W_CALL_JR   = 32'h0002_80E7; // register jump, rd=1, rs1=5
    localparam logic [31:0] W_CALL_JR1  = 32'h0000_80E7; // register jump, rd=1, rs1=1
    localparam logic [31:0] W_RET       = 32'h0000_8067; // register jump, rd=0, rs1=1
    localparam logic [31:0] W_ADDI      = 32'h0040_8093; // plain arithmetic
    localparam logic [31:0] W_JL_X5     = 32'h0000_02EF; // jump-and-link, rd=5
    localparam logic [31:0] W_JR_RS5    = 32'h0002_8067; // register jump, rd=0, rs1=5
    localparam logic [31:0] W_JR_F3     = 32'h0000_9067; // rd=0, rs1=1, funct3=001

    // {instr, pc, expected valid, expected target}
    localparam logic [96:0] VEC [NVEC] = '{
        {W_CALL_JL,  32'h0000_0100, 1'b0, 32'h0},          // R1 push 0x104
        {W_CALL_JR,  32'h0000_0200, 1'b0, 32'h0},          // R2 push 0x204
        {W_ADDI,     32'h0000_0300, 1'b0, 32'h0},          // R7
        {W_JL_X5,    32'h0000_0304, 1'b0, 32'h0},          // R7
        {W_JR_RS5,   32'h0000_0308, 1'b0, 32'h0},          // R7
        {W_JR_F3,    32'h0000_030C, 1'b0, 32'h0},          // R7
        {W_RET,      32'h0000_0400, 1'b1, 32'h0000_0204},  // R3 R4
        {W_CALL_JR1, 32'h0000_0500, 1'b0, 32'h0},          // R2 push 0x504
        {W_RET,      32'h0000_0404, 1'b1, 32'h0000_0504},  // R4
        {W_RET,      32'h0000_0408, 1'b1, 32'h0000_0104},  // R4
        {W_RET,      32'h0000_040C, 1'b0, 32'h0},          // R6 empty
        {W_CALL_JL,  32'h0000_0600, 1'b0, 32'h0},          // R6 push 0x604
        {W_RET,      32'h0000_0410, 1'b1, 32'h0000_0604},  // R6
        {W_RET,      32'h0000_0414, 1'b0, 32'h0}           // R6
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [31:0]     in_instr = '0;
    logic [XLEN-1:0] in_pc = '0;
    logic            pred_valid;
    logic [XLEN-1:0] pred_target;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ret_addr_stack #(.DEPTH(DEPTH), .XLEN(XLEN)) i_ret_addr_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_instr    (in_instr),
        .in_pc       (in_pc),
        .pred_valid  (pred_valid),
        .pred_target (pred_target)
    );

    task automatic step(input logic v, input logic [31:0] w, input logic [31:0] pc,
                        input logic ev, input logic [31:0] et, input string req);
        @(negedge clk);
        in_valid = v;
        in_instr = w;
        in_pc    = pc;
        #1;
        checks++;
        if (pred_valid !== ev || pred_target !== et) begin
            errors++;
            $display("FAIL %s: got valid=%0b target=%h, expected valid=%0b target=%h",
                     req, pred_valid, pred_target, ev, et);
        end
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                $display("FAIL watchdog: got timeout, expected completion");
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        // R8: reset state, a return predicts nothing
        step(1'b1, W_RET, 32'h0000_0010, 1'b0, 32'h0, "R8");
        rst_n = 1'b1;
        step(1'b1, W_RET, 32'h0000_0014, 1'b0, 32'h0, "R8");

        for (int i = 0; i < NVEC; i++) begin
            step(1'b1, VEC[i][96:65], VEC[i][64:33], VEC[i][32], VEC[i][31:0], "R1-table");
        end

        // R5: overflow, DEPTH+1 calls then drain
        for (int i = 0; i <= DEPTH; i++) begin
            step(1'b1, W_CALL_JL, 32'h0000_1000 + 32'(i * 16), 1'b0, 32'h0, "R5");
        end
        for (int i = DEPTH; i >= 1; i--) begin
            step(1'b1, W_RET, 32'h0000_2000, 1'b1, 32'h0000_1004 + 32'(i * 16), "R5");
        end
        step(1'b1, W_RET, 32'h0000_2004, 1'b0, 32'h0, "R5");

        // R9: idle slot carries a return and a call, neither acts
        step(1'b1, W_CALL_JL, 32'h0000_0A00, 1'b0, 32'h0, "R9");
        step(1'b0, W_RET, 32'h0000_0B00, 1'b0, 32'h0, "R9");
        step(1'b0, W_CALL_JL, 32'h0000_0C00, 1'b0, 32'h0, "R9");
        step(1'b1, W_RET, 32'h0000_0B04, 1'b1, 32'h0000_0A04, "R9");
        step(1'b1, W_RET, 32'h0000_0B08, 1'b0, 32'h0, "R9");

        // R8: reset in mid operation empties the stack
        step(1'b1, W_CALL_JL, 32'h0000_0D00, 1'b0, 32'h0, "R8");
        step(1'b1, W_CALL_JL, 32'h0000_0E00, 1'b0, 32'h0, "R8");
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b1, W_RET, 32'h0000_0F00, 1'b0, 32'h0, "R8");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule